// File: doc/BRIEF.md
# Multi-Pattern PRBS Sample Checker

This block watches one converter channel's deframed raw samples and decides whether they follow a pseudo-random test sequence. A three-bit select input picks the sequence at run time. Five recurrences are available: PN7, PN9, PN15, PN23 and PN31. Build-time enables can remove the three optional ones. The checker keeps a 31-bit history of sequence bits and predicts each new sample from that history. While it is out of sync, it refills the history from the received data, so it can align to the stream without a shared start point. Once locked, it runs on its own predictions.

Two flags come out. The out-of-sync flag is live and shows whether the checker is currently aligned. The error flag is sticky: it records any mismatch seen while aligned and stays set until the clear strobe. The checker sits ahead of any output formatting. A build-time parameter states whether the test sequence arrives in two's-complement form (sign bit inverted) or in offset-binary form (unchanged).

Top module: `prbs_sample_chk`

## Requirements
- R1: After reset `oos_flag` is 1 and `err_flag` is 0.
- R2: Each sample carries DATA_W consecutive sequence bits, oldest bit in the MSB. Each bit equals the XOR of the bits a and b places earlier. The select codes map as follows: 0 is PN9 (a=9, b=5), 1 is PN23 (23, 18), 4 is PN7 (7, 6), 5 is PN15 (15, 14) and 7 is PN31 (31, 28).
- R3: Codes 2, 3 and 6 are unsupported. A code whose build-time enable is off is treated the same way (code 4 needs EN_PN7, code 5 needs EN_PN15, code 7 needs EN_PN31). An unsupported code holds `oos_flag` at 1, and `err_flag` never sets while it is selected.
- R4: With TWOS_COMP=1, the sample MSB is inverted before comparison. With TWOS_COMP=0, the sample is compared as received.
- R5: While out of sync, the history reloads from every valid sample. `oos_flag` clears on the clock edge that takes the LOCK_CNT-th consecutive valid sample equal to the prediction from the preceding received bits.
- R6: While locked, the history advances from its own predicted bits. Any valid mismatching sample sets `err_flag` on that edge, and the flag stays set. A single corrupt sample does not disturb the samples that follow it.
- R7: `err_clr` high at an edge clears `err_flag`. A mismatch that sets the flag on the same edge takes priority over the clear.
- R8: While locked, LOSS_CNT consecutive mismatching valid samples set `oos_flag` on the edge of the last one. Any matching sample restarts that count.
- R9: An edge at which `pat_sel` differs from its value at the previous edge sets `oos_flag`, clears both counts and ignores that edge's sample.
- R10: An edge with `smp_valid` low changes neither flag nor the history, provided the select code is unchanged and supported and `err_clr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Qualifies `smp_data` this cycle |
| smp_data | input | DATA_W | Raw deframed channel sample |
| pat_sel | input | 3 | Pattern select code |
| err_clr | input | 1 | Write-one-to-clear strobe for `err_flag` |
| err_flag | output | 1 | Sticky mismatch-while-locked flag |
| oos_flag | output | 1 | Live out-of-sync flag |

## Verification
Both flags are registered, so every result is due on the same rising edge that accepts the sample or the strobe. The bench drives inputs on the falling edge and reads the flags on the next falling edge, after the last stimulus of each step. The exact edges are checked as follows:
- Lock is checked exactly between the 16th and 17th samples of a fresh PN9 stream.
- Loss is checked exactly between the 63rd and 64th corrupt samples.
- Select change and clear are checked one edge after the stimulus.
- Lock on the longer patterns, whose history fills over several samples, is checked only after a generous count of samples.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

   localparam int HIST_W = 31;

   typedef struct packed {
      logic [4:0] ta;
      logic [4:0] tb;
      logic       ok;
   } tap_t;

   function automatic tap_t tap_lookup(input logic [2:0] sel,
                                       input bit en7, input bit en15, input bit en31);
      tap_t t;
      t = '{ta: 5'd1, tb: 5'd1, ok: 1'b0};
      case (sel)
         3'd0: t = '{ta: 5'd9,  tb: 5'd5,  ok: 1'b1};
         3'd1: t = '{ta: 5'd23, tb: 5'd18, ok: 1'b1};
         3'd4: if (en7)  t = '{ta: 5'd7,  tb: 5'd6,  ok: 1'b1};
         3'd5: if (en15) t = '{ta: 5'd15, tb: 5'd14, ok: 1'b1};
         3'd7: if (en31) t = '{ta: 5'd31, tb: 5'd28, ok: 1'b1};
         default: t = '{ta: 5'd1, tb: 5'd1, ok: 1'b0};
      endcase
      return t;
   endfunction

endpackage

// File: rtl/prbs_fmt.sv
module prbs_fmt #(
   parameter int DATA_W    = 16,
   parameter bit TWOS_COMP = 1'b1
) (
   input  logic [DATA_W-1:0] raw_i,
   output logic [DATA_W-1:0] pat_o
);
   localparam logic [DATA_W-1:0] SIGN_MASK = {1'b1, {(DATA_W-1){1'b0}}};

   generate
      if (TWOS_COMP) begin : g_twos
         assign pat_o = raw_i ^ SIGN_MASK;
      end else begin : g_offset
         assign pat_o = raw_i;
      end
   endgenerate
endmodule

// File: rtl/prbs_predict.sv
module prbs_predict
   import prbs_chk_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [HIST_W-1:0] hist_i,
   input  tap_t              tap_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] pred_o,
   output logic [HIST_W-1:0] shifted_o
);
   logic [HIST_W-1:0] s;
   logic              nb;

   always_comb begin
      s      = hist_i;
      pred_o = '0;
      nb     = 1'b0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         nb        = s[tap_i.ta - 5'd1] ^ s[tap_i.tb - 5'd1];
         pred_o[i] = nb;
         s         = {s[HIST_W-2:0], nb};
      end
   end

   generate
      if (DATA_W < HIST_W) begin : g_partial
         assign shifted_o = {hist_i[HIST_W-DATA_W-1:0], word_i};
      end else begin : g_full
         assign shifted_o = word_i[HIST_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/prbs_lock_ctl.sv
module prbs_lock_ctl #(
   parameter int LOCK_CNT = 16,
   parameter int LOSS_CNT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid_i,
   input  logic match_i,
   input  logic sel_ok_i,
   input  logic sel_chg_i,
   input  logic clr_i,
   output logic oos_o,
   output logic err_o
);
   localparam int HW = $clog2(LOCK_CNT + 1);
   localparam int MW = $clog2(LOSS_CNT + 1);
   localparam logic [HW-1:0] HIT_LAST  = HW'(LOCK_CNT - 1);
   localparam logic [MW-1:0] MISS_LAST = MW'(LOSS_CNT - 1);

   logic [HW-1:0] hit_q;
   logic [MW-1:0] miss_q;
   logic          hold;
   logic          err_set;

   assign hold    = sel_chg_i || !sel_ok_i;
   assign err_set = !hold && valid_i && !oos_o && !match_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oos_o  <= 1'b1;
         hit_q  <= '0;
         miss_q <= '0;
      end else if (hold) begin
         oos_o  <= 1'b1;
         hit_q  <= '0;
         miss_q <= '0;
      end else if (valid_i) begin
         if (oos_o) begin
            miss_q <= '0;
            if (!match_i)              hit_q <= '0;
            else if (hit_q == HIT_LAST) begin
               oos_o <= 1'b0;
               hit_q <= '0;
            end else                   hit_q <= hit_q + 1'b1;
         end else begin
            hit_q <= '0;
            if (match_i)                miss_q <= '0;
            else if (miss_q == MISS_LAST) begin
               oos_o  <= 1'b1;
               miss_q <= '0;
            end else                    miss_q <= miss_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       err_o <= 1'b0;
      else if (err_set) err_o <= 1'b1;
      else if (clr_i)   err_o <= 1'b0;
   end

   // R3
   bad_sel_oos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok_i |=> oos_o);
   // R3
   bad_sel_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ok_i && !err_o) |=> !err_o);
   // R9
   sel_chg_oos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_chg_i |=> oos_o);
   // R5
   lock_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oos_o && !(valid_i && match_i)) |=> oos_o);
   // R7
   clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(valid_i && !match_i)) |=> !err_o);
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && sel_ok_i && !sel_chg_i && !clr_i) |=> ($stable(oos_o) && $stable(err_o)));
endmodule

// File: rtl/prbs_sample_chk.sv
module prbs_sample_chk
   import prbs_chk_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit TWOS_COMP = 1'b1,
   parameter bit EN_PN7    = 1'b1,
   parameter bit EN_PN15   = 1'b1,
   parameter bit EN_PN31   = 1'b1,
   parameter int LOCK_CNT  = 16,
   parameter int LOSS_CNT  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [2:0]        pat_sel,
   input  logic              err_clr,
   output logic              err_flag,
   output logic              oos_flag
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("prbs_sample_chk: DATA_W must be at least 2");
      end
      if (LOCK_CNT < 1 || LOSS_CNT < 1) begin : g_bad_cnt
         $error("prbs_sample_chk: LOCK_CNT and LOSS_CNT must be positive");
      end
   endgenerate

   tap_t              tap;
   logic [2:0]        sel_q;
   logic              sel_chg;
   logic [DATA_W-1:0] pat_word;
   logic [DATA_W-1:0] pred;
   logic [DATA_W-1:0] next_word;
   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_nxt;
   logic              match;

   assign tap       = tap_lookup(pat_sel, EN_PN7, EN_PN15, EN_PN31);
   assign sel_chg   = (pat_sel != sel_q);
   assign match     = (pred == pat_word);
   assign next_word = oos_flag ? pat_word : pred;

   prbs_fmt #(.DATA_W(DATA_W), .TWOS_COMP(TWOS_COMP)) u_fmt (
      .raw_i (smp_data),
      .pat_o (pat_word)
   );

   prbs_predict #(.DATA_W(DATA_W)) u_pred (
      .hist_i    (hist_q),
      .tap_i     (tap),
      .word_i    (next_word),
      .pred_o    (pred),
      .shifted_o (hist_nxt)
   );

   prbs_lock_ctl #(.LOCK_CNT(LOCK_CNT), .LOSS_CNT(LOSS_CNT)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (smp_valid),
      .match_i   (match),
      .sel_ok_i  (tap.ok),
      .sel_chg_i (sel_chg),
      .clr_i     (err_clr),
      .oos_o     (oos_flag),
      .err_o     (err_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= 3'd0;
         hist_q <= '0;
      end else begin
         sel_q <= pat_sel;
         if (smp_valid && !sel_chg) hist_q <= hist_nxt;
      end
   end

   // R10
   idle_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(hist_q));
   // R6
   err_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(!oos_flag && smp_valid));
endmodule

// File: tb/prbs_sample_chk_bench.sv
module prbs_sample_chk_bench;
   localparam int W = 16;

   typedef struct packed {
      logic [2:0] sel;
      int         cnt;
      logic       bad;
      logic       oos1;
      logic       err1;
      logic       oos2;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 16, 1'b0, 1'b1, 1'b0, 1'b1},   // R5 not yet
      '{3'd0, 1,  1'b0, 1'b0, 1'b0, 1'b0},   // R5 exact lock
      '{3'd0, 1,  1'b1, 1'b0, 1'b1, 1'b0},   // R6 set
      '{3'd0, 5,  1'b0, 1'b0, 1'b1, 1'b0},   // R6 sticky, stays locked
      '{3'd0, 63, 1'b1, 1'b0, 1'b1, 1'b0},   // R8 not yet
      '{3'd0, 1,  1'b1, 1'b1, 1'b1, 1'b1},   // R8 exact loss
      '{3'd5, 1,  1'b0, 1'b1, 1'b1, 1'b1},   // R9 change
      '{3'd5, 30, 1'b0, 1'b0, 1'b1, 1'b0},   // R2 PN15
      '{3'd1, 30, 1'b0, 1'b0, 1'b1, 1'b0},   // R2 PN23
      '{3'd4, 30, 1'b0, 1'b0, 1'b1, 1'b0},   // R2 PN7
      '{3'd7, 30, 1'b0, 1'b0, 1'b1, 1'b1},   // R2 PN31, R3 disabled on 2nd
      '{3'd2, 30, 1'b0, 1'b1, 1'b1, 1'b1},   // R3 unsupported
      '{3'd0, 30, 1'b0, 1'b0, 1'b1, 1'b0}    // R2 back to PN9
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [W-1:0]  d1 = '0, d2 = '0;
   logic [2:0]    pat_sel = 3'd0;
   logic          err_clr = 1'b0;
   logic          err1, oos1, err2, oos2;
   logic [30:0]   g_hist = 31'h5A3C_0100;
   int            total = 0, bad = 0;

   always #2 clk = ~clk;

   prbs_sample_chk u_prbs_sample_chk (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(d1),
      .pat_sel(pat_sel), .err_clr(err_clr), .err_flag(err1), .oos_flag(oos1));

   prbs_sample_chk #(.TWOS_COMP(1'b0), .EN_PN31(1'b0)) u_prbs_sample_chk_alt (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(d2),
      .pat_sel(pat_sel), .err_clr(err_clr), .err_flag(err2), .oos_flag(oos2));

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic gen(input logic [2:0] sel, output logic [W-1:0] w);
      int a, b;
      logic nb;
      case (sel)
         3'd1:    begin a = 23; b = 18; end
         3'd4:    begin a = 7;  b = 6;  end
         3'd5:    begin a = 15; b = 14; end
         3'd7:    begin a = 31; b = 28; end
         default: begin a = 9;  b = 5;  end
      endcase
      for (int i = W - 1; i >= 0; i--) begin
         nb     = g_hist[a-1] ^ g_hist[b-1];
         w[i]   = nb;
         g_hist = {g_hist[29:0], nb};
      end
   endtask

   // R4: main instance gets sign-inverted words, alternate gets them as-is
   task automatic send(input logic [2:0] sel, input int n, input logic corrupt,
                       input logic clr_first);
      logic [W-1:0] w;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         gen(sel, w);
         if (corrupt) w = w ^ 16'h0001;
         pat_sel   = sel;
         d1        = w ^ 16'h8000;
         d2        = w;
         smp_valid = 1'b1;
         err_clr   = clr_first && (k == 0);
      end
      @(negedge clk);
      smp_valid = 1'b0;
      err_clr   = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
   endtask

   initial begin
      #600000;
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 oos after reset", oos1, 1'b1);
      check("R1 err after reset", err1, 1'b0);
      check("R1 oos after reset alt", oos2, 1'b1);

      for (int v = 0; v < NV; v++) begin
         send(VEC[v].sel, VEC[v].cnt, VEC[v].bad, 1'b0);
         check($sformatf("R2/R5/R8/R9 row %0d oos", v), oos1, VEC[v].oos1);
         check($sformatf("R6 row %0d err", v), err1, VEC[v].err1);
         check($sformatf("R3/R4 row %0d oos alt", v), oos2, VEC[v].oos2);
      end

      // R7: clear with no sample
      pulse_clr();
      check("R7 clear", err1, 1'b0);
      // R7: mismatch and clear on the same edge, set wins
      send(3'd0, 1, 1'b1, 1'b1);
      check("R7 set over clear", err1, 1'b1);
      pulse_clr();

      // R10: idle cycles with garbage data change nothing
      @(negedge clk);
      d1 = 16'hDEAD;
      d2 = 16'hBEEF;
      repeat (50) @(negedge clk);
      check("R10 oos held idle", oos1, 1'b0);
      check("R10 err held idle", err1, 1'b0);
      send(3'd0, 3, 1'b0, 1'b0);
      check("R10 history untouched", err1, 1'b0);

      // R8: one match restarts the loss count
      send(3'd0, 40, 1'b1, 1'b0);
      send(3'd0, 1, 1'b0, 1'b0);
      send(3'd0, 63, 1'b1, 1'b0);
      check("R8 count restarted", oos1, 1'b0);
      send(3'd0, 1, 1'b1, 1'b0);
      check("R8 loss after restart", oos1, 1'b1);

      // R3: unsupported code never sets error
      pulse_clr();
      send(3'd3, 10, 1'b1, 1'b0);
      check("R3 err stays clear", err1, 1'b0);
      check("R3 oos forced", oos1, 1'b1);
      send(3'd6, 10, 1'b0, 1'b0);
      check("R3 code 6 oos", oos1, 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule